// File: doc/BRIEF.md
# TMDS Lane Test-Pattern Generator

This block is a self-test source placed in front of one 10-bit TMDS lane. A 3-bit select decides what the lane carries on each clock: the encoded symbol stream from the upstream encoder, a pseudo-random bit sequence, a programmable rotating word pattern, or all zeros. The result is registered once before it leaves the block, so every output word reflects the controls and data present one clock earlier.

The pseudo-random engine has four selectable feedback polynomials. It can hand out its bits one, eight or ten at a time; in each cycle it advances by exactly as many steps as it emits. The rotating-pattern engine takes an 80-bit vector as eight 10-bit words and shows them in ascending order. It holds each word for a programmable number of cycles, from 1 to 8. Every control is a plain input port, driven by a register bank that lives elsewhere.

Top module: `tmds_bist_gen`

## Requirements
- R1: `lane_sel` 3'b000, and every code other than 3'b001, 3'b010 and 3'b100, drives `lane_out` to all zeros one clock later.
- R2: With `lane_sel` = 3'b001, `lane_out` equals the `tmds_data` value sampled at the previous rising clock edge.
- R3: With `lane_sel` = 3'b010, `prbs_mode` selects the polynomial: 0 gives x^11+x^9+1, 1 gives x^15+x^14+1, 2 gives x^7+x^6+1, 3 gives x^31+x^28+1. Each new bit is e(t) = e(t-N) xor e(t-T) for polynomial x^N+x^T+1, and the history starts as N ones. Bits emitted in one cycle fill `lane_out` from bit 0 upward in order of generation.
- R4: `prbs_width` 1 emits 8 bits per cycle, 2 emits 1 bit and 3 emits 10 bits. The sequence advances by that count each cycle, and the upper bits left unused read as zero.
- R5: `prbs_width` 0, or `prbs_en` low, gives zero output in PRBS mode. While `prbs_en` is low the generator is reseeded to all ones, so enabling it restarts the sequence.
- R6: A change of `prbs_mode` while enabled restarts the sequence from the all-ones seed in the same cycle that the new mode is first used.
- R7: With `lane_sel` = 3'b100 and `shift_en` high, words are shown starting from `shift_pattern[9:0]` and rising through `[79:70]`. After `[79:70]` the sequence wraps back to `[9:0]`.
- R8: Each pattern word stays on `lane_out` for `shift_hold`+1 consecutive cycles (1 to 8).
- R9: With `shift_en` low, the pattern output is zero and the word index and hold counter return to zero. The first word after re-enabling is `[9:0]`.
- R10: While `rst_n` is low at a rising edge, `lane_out` becomes zero and both engines return to their initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_sel | input | 3 | Output source select |
| tmds_data | input | 10 | Encoded symbol from the upstream encoder |
| prbs_en | input | 1 | Pseudo-random engine enable |
| prbs_mode | input | 2 | Polynomial select |
| prbs_width | input | 2 | Bits emitted per cycle select |
| shift_en | input | 1 | Rotating-pattern engine enable |
| shift_hold | input | 3 | Cycles per word minus one |
| shift_pattern | input | 80 | Eight 10-bit pattern words, word 0 in the low bits |
| lane_out | output | 10 | Registered lane output |

## Verification
The bound checker checks the per-cycle relations on every clock. These are zeroing for unused select codes, one-cycle pass-through, zero output for an idle or disabled engine, and zero upper bits in the narrow widths. The bench shows the behaviour that depends on history. It regenerates each polynomial's sequence from its recurrence and compares it across all four modes and three widths. It also covers reseeding on a mode change and on re-enable, and the order, hold time and wrap of the pattern words for every hold setting.

// File: rtl/tmds_bist_pkg.sv
// Package: shared encodings and polynomial lookup for the lane test generator.
// Assumes polynomials of the form x^N + x^T + 1 with N no wider than 31.
package tmds_bist_pkg;

    typedef enum logic [2:0] {
        SEL_ZERO  = 3'b000,
        SEL_DATA  = 3'b001,
        SEL_PRBS  = 3'b010,
        SEL_SHIFT = 3'b100
    } lane_sel_e;

    // Register length N for a polynomial select code
    function automatic int prbs_len(input logic [1:0] mode);
        case (mode)
            2'd0:    return 11;
            2'd1:    return 15;
            2'd2:    return 7;
            default: return 31;
        endcase
    endfunction

    // Middle tap T for a polynomial select code
    function automatic int prbs_tap(input logic [1:0] mode);
        case (mode)
            2'd0:    return 9;
            2'd1:    return 14;
            2'd2:    return 6;
            default: return 28;
        endcase
    endfunction

    // Bits emitted per cycle for a width select code
    function automatic int width_steps(input logic [1:0] width);
        case (width)
            2'd1:    return 8;
            2'd2:    return 1;
            2'd3:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tmds_prbs_src.sv
// Pseudo-random source: one shared register sized for the longest polynomial,
// masked to the selected length. Emits up to LANE_W bits per cycle, LSB first.
// Assumes REG_W is at least the longest polynomial length (31).
module tmds_prbs_src
    import tmds_bist_pkg::*;
#(
    parameter int LANE_W = 10,
    parameter int REG_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [1:0]        width,
    output logic [LANE_W-1:0] chunk
);

    logic [REG_W-1:0] st_q;
    logic [REG_W-1:0] st_eff;
    logic [REG_W-1:0] st_nxt;
    logic [REG_W-1:0] len_mask;
    logic [1:0]       mode_q;
    logic             fb;
    int               n_len;
    int               n_tap;
    int               n_steps;

    // Reseed in the very cycle a new mode is first seen
    always_comb st_eff = (mode != mode_q) ? '1 : st_q;

    // Unroll up to LANE_W register steps, collecting each feedback bit
    always_comb begin
        n_len    = prbs_len(mode);
        n_tap    = prbs_tap(mode);
        n_steps  = width_steps(width);
        len_mask = (REG_W'(1) << n_len) - REG_W'(1);
        st_nxt   = st_eff & len_mask;
        chunk    = '0;
        fb       = 1'b0;
        for (int k = 0; k < LANE_W; k++) begin
            if (k < n_steps) begin
                fb       = st_nxt[n_len-1] ^ st_nxt[n_tap-1];
                chunk[k] = fb;
                st_nxt   = ((st_nxt << 1) | REG_W'(fb)) & len_mask;
            end
        end
        if (!en) chunk = '0;
    end

    // State update: hold the seed while disabled, advance while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '1;
            mode_q <= '0;
        end else begin
            mode_q <= mode;
            st_q   <= en ? st_nxt : '1;
        end
    end

endmodule

// File: rtl/tmds_shift_src.sv
// Rotating-word source: slices the pattern vector into WORDS words and
// steps through them in ascending order, holding each for hold+1 cycles.
// Assumes WORDS is a power of two or wraps explicitly at WORDS-1.
module tmds_shift_src #(
    parameter int LANE_W = 10,
    parameter int WORDS  = 8,
    parameter int HOLD_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [HOLD_W-1:0]        hold,
    input  logic [LANE_W*WORDS-1:0]  pattern,
    output logic [LANE_W-1:0]        word
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [LANE_W-1:0] words [WORDS];
    logic [IDX_W-1:0]  idx_q;
    logic [HOLD_W-1:0] hold_q;

    for (genvar g = 0; g < WORDS; g++) begin : g_slice
        assign words[g] = pattern[g*LANE_W +: LANE_W];
    end

    // Present the current word only while enabled
    always_comb word = en ? words[idx_q] : '0;

    // Word index and hold counter; cleared whenever the engine is off
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            idx_q  <= '0;
            hold_q <= '0;
        end else if (hold_q >= hold) begin
            hold_q <= '0;
            idx_q  <= (idx_q == IDX_W'(WORDS-1)) ? '0 : idx_q + 1'b1;
        end else begin
            hold_q <= hold_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmds_bist_gen.sv
// Lane test-pattern generator top: picks zeros, pass-through data, the
// pseudo-random source or the rotating-word source and registers the result.
// Assumes all controls are static or change only between clock edges.
module tmds_bist_gen
    import tmds_bist_pkg::*;
#(
    parameter int LANE_W = 10,
    parameter int WORDS  = 8,
    parameter int HOLD_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              lane_sel,
    input  logic [LANE_W-1:0]       tmds_data,
    input  logic                    prbs_en,
    input  logic [1:0]              prbs_mode,
    input  logic [1:0]              prbs_width,
    input  logic                    shift_en,
    input  logic [HOLD_W-1:0]       shift_hold,
    input  logic [LANE_W*WORDS-1:0] shift_pattern,
    output logic [LANE_W-1:0]       lane_out
);

    logic [LANE_W-1:0] prbs_word;
    logic [LANE_W-1:0] shift_word;
    logic [LANE_W-1:0] mux_word;

    tmds_prbs_src #(.LANE_W(LANE_W), .REG_W(31)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (prbs_en),
        .mode  (prbs_mode),
        .width (prbs_width),
        .chunk (prbs_word)
    );

    tmds_shift_src #(.LANE_W(LANE_W), .WORDS(WORDS), .HOLD_W(HOLD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (shift_en),
        .hold    (shift_hold),
        .pattern (shift_pattern),
        .word    (shift_word)
    );

    // Source select; undefined codes fall to zero
    always_comb begin
        case (lane_sel)
            SEL_DATA:  mux_word = tmds_data;
            SEL_PRBS:  mux_word = prbs_word;
            SEL_SHIFT: mux_word = shift_word;
            default:   mux_word = '0;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) lane_out <= '0;
        else        lane_out <= mux_word;
    end

endmodule

// File: rtl/tmds_bist_checks.sv
// Checker for the lane generator: per-cycle output relations, bound to the top.
module tmds_bist_checks #(
    parameter int LANE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        lane_sel,
    input logic [LANE_W-1:0] tmds_data,
    input logic              prbs_en,
    input logic [1:0]        prbs_width,
    input logic              shift_en,
    input logic [LANE_W-1:0] lane_out
);

    logic known_code;
    always_comb known_code = (lane_sel == 3'b001) || (lane_sel == 3'b010) || (lane_sel == 3'b100);

    // R1: unused select codes give a zero lane
    p_zero_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !known_code |=> lane_out == '0);

    // R2: pass-through is one register late
    p_pass_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_sel == 3'b001 |=> lane_out == $past(tmds_data));

    // R5: idle width or disabled engine gives zero
    p_prbs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel == 3'b010 && (!prbs_en || prbs_width == 2'd0)) |=> lane_out == '0);

    // R4: single-bit width leaves upper bits clear
    p_prbs_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel == 3'b010 && prbs_width == 2'd2) |=> lane_out[LANE_W-1:1] == '0);

    // R4: eight-bit width leaves the top two bits clear
    p_prbs_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel == 3'b010 && prbs_width == 2'd1) |=> lane_out[LANE_W-1:8] == '0);

    // R9: disabled rotating engine gives zero
    p_shift_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel == 3'b100 && !shift_en) |=> lane_out == '0);

endmodule

bind tmds_bist_gen tmds_bist_checks #(.LANE_W(LANE_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_sel   (lane_sel),
    .tmds_data  (tmds_data),
    .prbs_en    (prbs_en),
    .prbs_width (prbs_width),
    .shift_en   (shift_en),
    .lane_out   (lane_out)
);

// File: tb/tb_tmds_bist_gen.sv
// Self-checking bench: sweeps select codes, every polynomial and width,
// and every hold value, with expected values from the requirements.
module tb_tmds_bist_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  lane_sel = '0;
    logic [9:0]  tmds_data = '0;
    logic        prbs_en = 1'b0;
    logic [1:0]  prbs_mode = '0;
    logic [1:0]  prbs_width = '0;
    logic        shift_en = 1'b0;
    logic [2:0]  shift_hold = '0;
    logic [79:0] shift_pattern = '0;
    logic [9:0]  lane_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmds_bist_gen dut (
        .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .tmds_data(tmds_data),
        .prbs_en(prbs_en), .prbs_mode(prbs_mode), .prbs_width(prbs_width),
        .shift_en(shift_en), .shift_hold(shift_hold),
        .shift_pattern(shift_pattern), .lane_out(lane_out)
    );

    // Reference bit history for the recurrence e(t) = e(t-N) ^ e(t-T)
    bit hist[$];
    int ref_n;
    int ref_t;

    task automatic reseed(input int mode);
        case (mode)
            0: begin ref_n = 11; ref_t = 9;  end
            1: begin ref_n = 15; ref_t = 14; end
            2: begin ref_n = 7;  ref_t = 6;  end
            default: begin ref_n = 31; ref_t = 28; end
        endcase
        hist.delete();
        for (int i = 0; i < ref_n; i++) hist.push_back(1'b1);
    endtask

    function automatic bit next_bit();
        bit b;
        b = hist[hist.size()-ref_n] ^ hist[hist.size()-ref_t];
        hist.push_back(b);
        if (hist.size() > 40) void'(hist.pop_front());
        return b;
    endfunction

    function automatic logic [9:0] ref_chunk(input int width);
        logic [9:0] w;
        int cnt;
        w = '0;
        cnt = (width == 1) ? 8 : (width == 2) ? 1 : (width == 3) ? 10 : 0;
        for (int k = 0; k < cnt; k++) w[k] = next_bit();
        return w;
    endfunction

    function automatic logic [9:0] pat_word(input int j);
        return 10'((j * 97 + 41) ^ (j << 6));
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lane_out=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 8; j++) shift_pattern[j*10 +: 10] = pat_word(j);
        tmds_data = 10'h2B5;
        lane_sel  = 3'b001;
        repeat (3) tick();
        chk("R10 reset", lane_out, 10'h000);
        rst_n = 1'b1;

        // R1 / R2: sweep every select code over several data values
        prbs_en = 1'b1; prbs_width = 2'd3; shift_en = 1'b1;
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 6; v++) begin
                lane_sel  = 3'(s);
                tmds_data = 10'(v * 171 + 3);
                tick();
                if (s == 1) chk("R2 pass-through", lane_out, 10'(v * 171 + 3));
                else if (s != 2 && s != 4) chk("R1 zero code", lane_out, 10'h000);
            end
        end
        prbs_en = 1'b0; shift_en = 1'b0;
        tick();

        // R3 / R4 / R5: every polynomial at every width, restarted by enable
        lane_sel = 3'b010;
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 4; w++) begin
                prbs_en = 1'b0; prbs_mode = 2'(m); prbs_width = 2'(w);
                tick();
                chk("R5 disabled", lane_out, 10'h000);
                prbs_en = 1'b1;
                reseed(m);
                for (int c = 0; c < 40; c++) begin
                    tick();
                    if (w == 0) chk("R5 idle width", lane_out, 10'h000);
                    else chk("R3 R4 sequence", lane_out, ref_chunk(w));
                end
            end
        end

        // R6: mode switch while enabled restarts from the seed at once
        prbs_en = 1'b0; prbs_mode = 2'd0; prbs_width = 2'd3;
        tick();
        prbs_en = 1'b1;
        reseed(0);
        for (int c = 0; c < 5; c++) begin
            tick();
            chk("R6 before switch", lane_out, ref_chunk(3));
        end
        prbs_mode = 2'd2;
        reseed(2);
        for (int c = 0; c < 12; c++) begin
            tick();
            chk("R6 after switch", lane_out, ref_chunk(3));
        end
        prbs_en = 1'b0;

        // R7 / R8 / R9: every hold value, two full rotations plus a partial
        lane_sel = 3'b100;
        for (int h = 0; h < 8; h++) begin
            shift_en = 1'b0; shift_hold = 3'(h);
            tick();
            chk("R9 disabled", lane_out, 10'h000);
            shift_en = 1'b1;
            for (int c = 0; c < 16 * (h + 1) + 5; c++) begin
                tick();
                chk("R7 R8 word order", lane_out, pat_word((c / (h + 1)) % 8));
            end
        end

        // R9: disable mid-sequence, then restart from word 0
        shift_hold = 3'd1;
        shift_en = 1'b0;
        tick();
        shift_en = 1'b1;
        for (int c = 0; c < 7; c++) tick();
        chk("R9 mid-run word", lane_out, pat_word(3));
        shift_en = 1'b0;
        tick();
        chk("R9 off", lane_out, 10'h000);
        shift_en = 1'b1;
        tick();
        chk("R9 restart word 0", lane_out, pat_word(0));

        // R10: reset in the middle of pattern output
        rst_n = 1'b0;
        tick();
        chk("R10 mid-run reset", lane_out, 10'h000);
        rst_n = 1'b1;
        tick();
        chk("R10 restart after reset", lane_out, pat_word(0));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule